// File: doc/BRIEF.md
# Dual Packet Rendezvous Comparator

This block sits on the outgoing path of a router in a node that runs as the master half of a redundant pair. Two cores execute the same program: the local master core and a partner mirror core elsewhere in the mesh. The partner's output packets are steered back to the master's router. The block holds each outgoing packet until the equivalent packet from the partner has arrived. It then walks both wormhole packets together, one flit pair per transfer, sends the master's copy on into the network and raises a sticky error flag as soon as any flit pair disagrees.

In the head flit, the low `ID_W` bits carry the destination ID and the next `ID_W` bits carry the sender ID. The partner's sender ID legitimately differs from the master's, so the head comparison skips that field. Instead, the field is checked against the partner ID that software configured. A registered counter reports how many cycles the first-arriving head waited for its partner at the most recent rendezvous. When the node is not configured as master, the block passes the local stream straight through.

Top module: `rdv_comparator`

## Requirements
- R1: After reset `err_flag` is 0, `wait_cycles` is 0, and the block is waiting for a pair of head flits.
- R2: In master mode, a flit pair transfers only when `m_valid`, `r_valid` and `o_ready` are all high. In that cycle both `m_ready` and `r_ready` are high and `o_valid` is high. Otherwise no flit that would have been forwarded is consumed.
- R3: The forwarded flit carries the master's `m_data` and `m_head`. `o_tail` is the OR of both tail flags, so the outgoing packet closes when either packet ends.
- R4: In a head pair, bits [2*ID_W-1:ID_W] (sender ID) are excluded from the data comparison. Bits [ID_W-1:0] (destination) and all higher bits are compared.
- R5: If the mirror head's sender field differs from `cfg_mirror_id`, an error is raised.
- R6: Any data difference in a transferred pair sets `err_flag` on the following clock edge.
- R7: A pair whose tail flags differ raises an error and ends the packet. Non-head flits that remain on either input while the block waits for heads are consumed and not forwarded.
- R8: `err_flag` stays set until `err_clr` is high at a clock edge. A new error in the same cycle as `err_clr` leaves the flag set.
- R9: `wait_cycles` is updated only at a head-pair transfer. It then takes the number of cycles since the previous rendezvous in which exactly one input offered a valid head, saturating at its maximum.
- R10: With `cfg_master` low, the output follows the master input (`o_valid`=`m_valid`, `m_ready`=`o_ready`), `r_ready` is 0, and `err_flag` and `wait_cycles` do not change.
- R11: While waiting for heads, a pair is only formed when both inputs present head flits. A head on one input alone is not consumed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_master | input | 1 | Node configured as master; enables rendezvous and comparison |
| cfg_mirror_id | input | ID_W | Expected sender ID of the mirror's packets |
| m_valid | input | 1 | Master flit valid |
| m_ready | output | 1 | Master flit accepted |
| m_data | input | FLIT_W | Master flit contents |
| m_head | input | 1 | Master flit is a head flit |
| m_tail | input | 1 | Master flit is a tail flit |
| r_valid | input | 1 | Mirror flit valid |
| r_ready | output | 1 | Mirror flit accepted |
| r_data | input | FLIT_W | Mirror flit contents |
| r_head | input | 1 | Mirror flit is a head flit |
| r_tail | input | 1 | Mirror flit is a tail flit |
| o_valid | output | 1 | Forwarded flit valid |
| o_ready | input | 1 | Downstream accepts a flit |
| o_data | output | FLIT_W | Forwarded flit contents |
| o_head | output | 1 | Forwarded flit is a head |
| o_tail | output | 1 | Forwarded flit ends the packet |
| err_clr | input | 1 | Clears the sticky error flag |
| err_flag | output | 1 | Sticky mismatch indication |
| wait_cycles | output | CNT_W | Wait length of the last rendezvous |

## Verification
The hardest state to reach is the one right after a tail mismatch. One packet has ended, and the longer packet still has body flits queued while the block has gone back to waiting for heads. The stimulus sends a master packet of two flits and a mirror packet of three. It then offers the mirror's leftover body flit during the head-wait phase and watches that flit being drained with no output valid. The wait counter is driven asymmetrically: one head is held alone for a known number of cycles, first with the master ahead and then with the mirror ahead. A stalled head pair under back-pressure must not count as waiting.

// File: rtl/rdv_pkg.sv
package rdv_pkg;

    typedef enum logic {
        PH_MEET = 1'b0,
        PH_BODY = 1'b1
    } rdv_phase_e;

    typedef struct packed {
        rdv_phase_e phase;
    } rdv_ctrl_s;

endpackage

// File: rtl/rdv_flit_match.sv
module rdv_flit_match #(
    parameter int FLIT_W = 32,
    parameter int ID_W   = 8
) (
    input  logic [FLIT_W-1:0] m_data,
    input  logic [FLIT_W-1:0] r_data,
    input  logic              m_tail,
    input  logic              r_tail,
    input  logic              is_head,
    input  logic [ID_W-1:0]   mirror_id,
    output logic              mism
);
    localparam int SRC_LO = ID_W;
    localparam int SRC_HI = 2 * ID_W - 1;

    logic [FLIT_W-1:0] cmp_mask;
    logic              data_bad;
    logic              tail_bad;
    logic              src_bad;

    // R4: the sender field is excluded from the comparison of head flits
    for (genvar b = 0; b < FLIT_W; b++) begin : g_mask
        if (b >= SRC_LO && b <= SRC_HI) begin : g_src
            assign cmp_mask[b] = ~is_head;
        end else begin : g_oth
            assign cmp_mask[b] = 1'b1;
        end
    end

    always_comb begin
        data_bad = |((m_data ^ r_data) & cmp_mask);
        tail_bad = m_tail ^ r_tail;
        src_bad  = is_head && (r_data[SRC_HI:SRC_LO] != mirror_id);
        mism     = data_bad | tail_bad | src_bad;
    end
endmodule

// File: rtl/rdv_err_latch.sv
module rdv_err_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic clr,
    output logic flag
);
    logic flag_d, flag_q;

    always_comb begin
        flag_d = flag_q;
        if (clr) flag_d = 1'b0;
        if (set) flag_d = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flag_q <= 1'b0;
        else        flag_q <= flag_d;
    end

    assign flag = flag_q;

    a_r8_hold_until_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_q && !clr) |=> flag_q);
    a_r8_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        set |=> flag_q);
    a_r8_clear_works: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !set) |=> !flag_q);
endmodule

// File: rtl/rdv_wait_ctr.sv
module rdv_wait_ctr #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             waiting,
    input  logic             meet,
    output logic [CNT_W-1:0] wait_len
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    typedef struct packed {
        logic [CNT_W-1:0] run;
        logic [CNT_W-1:0] last;
    } ctr_s;

    ctr_s st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (meet) begin
            st_d.last = st_q.run;
            st_d.run  = '0;
        end else if (waiting && st_q.run != CNT_MAX) begin
            st_d.run = st_q.run + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign wait_len = st_q.last;

    a_r9_only_at_meet: assert property (@(posedge clk) disable iff (!rst_n)
        !meet |=> $stable(wait_len));
    a_r9_saturate: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.run == CNT_MAX && waiting && !meet) |=> st_q.run == CNT_MAX);
endmodule

// File: rtl/rdv_comparator.sv
module rdv_comparator
    import rdv_pkg::*;
#(
    parameter int FLIT_W = 32,
    parameter int ID_W   = 8,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_master,
    input  logic [ID_W-1:0]   cfg_mirror_id,
    input  logic              m_valid,
    output logic              m_ready,
    input  logic [FLIT_W-1:0] m_data,
    input  logic              m_head,
    input  logic              m_tail,
    input  logic              r_valid,
    output logic              r_ready,
    input  logic [FLIT_W-1:0] r_data,
    input  logic              r_head,
    input  logic              r_tail,
    output logic              o_valid,
    input  logic              o_ready,
    output logic [FLIT_W-1:0] o_data,
    output logic              o_head,
    output logic              o_tail,
    input  logic              err_clr,
    output logic              err_flag,
    output logic [CNT_W-1:0]  wait_cycles
);
    rdv_ctrl_s ctrl_d, ctrl_q;

    logic meet_ph;
    logic pair_ok;
    logic pair_fire;
    logic drain_m, drain_r;
    logic one_head;
    logic mism;

    always_comb begin
        meet_ph   = (ctrl_q.phase == PH_MEET);
        // R11: while waiting, only a head on both sides forms a pair
        pair_ok   = !meet_ph || (m_head && r_head);
        pair_fire = cfg_master && m_valid && r_valid && o_ready && pair_ok;
        // R7: leftover body flits seen while waiting for heads are discarded
        drain_m   = cfg_master && meet_ph && m_valid && !m_head;
        drain_r   = cfg_master && meet_ph && r_valid && !r_head;
        one_head  = cfg_master && meet_ph &&
                    ((m_valid && m_head) != (r_valid && r_head));

        if (cfg_master) begin
            o_valid = m_valid && r_valid && pair_ok;
            o_data  = m_data;
            o_head  = m_head;
            o_tail  = m_tail || r_tail;
            m_ready = pair_fire || drain_m;
            r_ready = pair_fire || drain_r;
        end else begin
            o_valid = m_valid;
            o_data  = m_data;
            o_head  = m_head;
            o_tail  = m_tail;
            m_ready = o_ready;
            r_ready = 1'b0;
        end

        ctrl_d = ctrl_q;
        if (!cfg_master) begin
            ctrl_d.phase = PH_MEET;
        end else if (pair_fire) begin
            ctrl_d.phase = (m_tail || r_tail) ? PH_MEET : PH_BODY;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctrl_q <= '{phase: PH_MEET};
        else        ctrl_q <= ctrl_d;
    end

    rdv_flit_match #(
        .FLIT_W (FLIT_W),
        .ID_W   (ID_W)
    ) match_i (
        .m_data    (m_data),
        .r_data    (r_data),
        .m_tail    (m_tail),
        .r_tail    (r_tail),
        .is_head   (meet_ph),
        .mirror_id (cfg_mirror_id),
        .mism      (mism)
    );

    rdv_err_latch err_i (
        .clk   (clk),
        .rst_n (rst_n),
        .set   (pair_fire && mism),
        .clr   (err_clr),
        .flag  (err_flag)
    );

    rdv_wait_ctr #(
        .CNT_W (CNT_W)
    ) wait_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .waiting  (one_head),
        .meet     (pair_fire && meet_ph),
        .wait_len (wait_cycles)
    );

    a_r2_pair_only: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_master && o_valid && o_ready) |-> (m_ready && r_ready));
    a_r6_flag_follows: assert property (@(posedge clk) disable iff (!rst_n)
        (pair_fire && mism) |=> err_flag);
    a_r10_mirror_held: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_master |-> !r_ready);
    a_r10_err_unchanged: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_master && !err_clr) |=> $stable(err_flag));
    a_r11_heads_first: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_master && meet_ph && o_valid) |-> (m_head && r_head));
endmodule

// File: tb/rdv_comparator_tb_top.sv
`timescale 1ns/1ps
module rdv_comparator_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_master = 1'b1;
    logic [7:0]  cfg_mirror_id = 8'h22;
    logic        m_valid = 0, m_head = 0, m_tail = 0;
    logic [31:0] m_data = '0;
    logic        r_valid = 0, r_head = 0, r_tail = 0;
    logic [31:0] r_data = '0;
    logic        o_ready = 1'b1;
    logic        err_clr = 1'b0;
    logic        m_ready, r_ready, o_valid, o_head, o_tail, err_flag;
    logic [31:0] o_data;
    logic [15:0] wait_cycles;

    int n_run = 0;
    int n_fail = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    rdv_comparator dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_master(cfg_master), .cfg_mirror_id(cfg_mirror_id),
        .m_valid(m_valid), .m_ready(m_ready), .m_data(m_data), .m_head(m_head), .m_tail(m_tail),
        .r_valid(r_valid), .r_ready(r_ready), .r_data(r_data), .r_head(r_head), .r_tail(r_tail),
        .o_valid(o_valid), .o_ready(o_ready), .o_data(o_data), .o_head(o_head), .o_tail(o_tail),
        .err_clr(err_clr), .err_flag(err_flag), .wait_cycles(wait_cycles)
    );

    function automatic logic [31:0] hd(input logic [7:0] dst, input logic [7:0] src,
                                       input logic [15:0] pl);
        return {pl, src, dst};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic put_m(input logic v, input logic h, input logic t, input logic [31:0] d);
        m_valid = v; m_head = h; m_tail = t; m_data = d;
    endtask

    task automatic put_r(input logic v, input logic h, input logic t, input logic [31:0] d);
        r_valid = v; r_head = h; r_tail = t; r_data = d;
    endtask

    task automatic idle_in();
        put_m(0, 0, 0, '0);
        put_r(0, 0, 0, '0);
    endtask

    task automatic clear_err();
        err_clr = 1'b1;
        step();
        err_clr = 1'b0;
        check("R8 clear", err_flag, 1'b0);
    endtask

    task automatic t_reset();
        check("R1 err", err_flag, 1'b0);
        check("R1 wait", wait_cycles, 16'd0);
        put_m(1, 0, 0, 32'h1);
        put_r(0, 0, 0, 32'h1);
        #1;
        check("R1 R11 no pair", o_valid, 1'b0);
        idle_in();
        step();
    endtask

    task automatic t_match();
        put_m(1, 1, 0, hd(8'h05, 8'h11, 16'hABCD));
        put_r(1, 1, 0, hd(8'h05, 8'h22, 16'hABCD));
        #1;
        check("R2 o_valid", o_valid, 1'b1);
        check("R2 m_ready", m_ready, 1'b1);
        check("R2 r_ready", r_ready, 1'b1);
        check("R3 head data", o_data, hd(8'h05, 8'h11, 16'hABCD));
        check("R3 head flag", o_head, 1'b1);
        step();
        put_m(1, 0, 1, 32'h1234_5678);
        put_r(1, 0, 1, 32'h1234_5678);
        #1;
        check("R3 tail", o_tail, 1'b1);
        check("R3 body data", o_data, 32'h1234_5678);
        step();
        idle_in();
        check("R4 src ignored", err_flag, 1'b0);
        check("R9 simultaneous", wait_cycles, 16'd0);
    endtask

    task automatic t_bad_src();
        put_m(1, 1, 1, hd(8'h05, 8'h11, 16'h0001));
        put_r(1, 1, 1, hd(8'h05, 8'h23, 16'h0001));
        step();
        idle_in();
        check("R5 wrong mirror id", err_flag, 1'b1);
        clear_err();
    endtask

    task automatic t_dst_diff();
        put_m(1, 1, 1, hd(8'h05, 8'h11, 16'h0001));
        put_r(1, 1, 1, hd(8'h06, 8'h22, 16'h0001));
        step();
        idle_in();
        check("R4 dst compared", err_flag, 1'b1);
        clear_err();
    endtask

    task automatic t_body_diff();
        put_m(1, 1, 0, hd(8'h05, 8'h11, 16'h0002));
        put_r(1, 1, 0, hd(8'h05, 8'h22, 16'h0002));
        step();
        check("R6 before mismatch", err_flag, 1'b0);
        put_m(1, 0, 1, 32'hAAAA_0000);
        put_r(1, 0, 1, 32'hAAAA_0001);
        step();
        idle_in();
        check("R6 body mismatch", err_flag, 1'b1);
        put_m(1, 1, 1, hd(8'h05, 8'h11, 16'h0003));
        put_r(1, 1, 1, hd(8'h05, 8'h22, 16'h0003));
        step();
        idle_in();
        check("R8 sticky", err_flag, 1'b1);
        put_m(1, 1, 1, hd(8'h05, 8'h11, 16'h0004));
        put_r(1, 1, 1, hd(8'h07, 8'h22, 16'h0004));
        err_clr = 1'b1;
        step();
        err_clr = 1'b0;
        idle_in();
        check("R8 set wins", err_flag, 1'b1);
        clear_err();
    endtask

    task automatic t_tail_diff();
        put_m(1, 1, 0, hd(8'h05, 8'h11, 16'h0005));
        put_r(1, 1, 0, hd(8'h05, 8'h22, 16'h0005));
        step();
        put_m(1, 0, 1, 32'h55);
        put_r(1, 0, 0, 32'h55);
        #1;
        check("R3 tail or", o_tail, 1'b1);
        step();
        put_m(0, 0, 0, '0);
        put_r(1, 0, 1, 32'h66);
        #1;
        check("R7 leftover drained", r_ready, 1'b1);
        check("R7 leftover not forwarded", o_valid, 1'b0);
        check("R7 tail mismatch", err_flag, 1'b1);
        step();
        idle_in();
        clear_err();
    endtask

    task automatic t_wait();
        put_m(1, 1, 1, hd(8'h05, 8'h11, 16'h0006));
        for (int i = 0; i < 5; i++) begin
            #1;
            check("R11 lone head held", m_ready, 1'b0);
            step();
        end
        put_r(1, 1, 1, hd(8'h05, 8'h22, 16'h0006));
        step();
        idle_in();
        check("R9 master first", wait_cycles, 16'd5);
        put_r(1, 1, 1, hd(8'h05, 8'h22, 16'h0007));
        step(); step(); step();
        check("R9 stable between", wait_cycles, 16'd5);
        put_m(1, 1, 1, hd(8'h05, 8'h11, 16'h0007));
        step();
        idle_in();
        check("R9 mirror first", wait_cycles, 16'd3);
    endtask

    task automatic t_slave();
        cfg_master = 1'b0;
        put_m(1, 1, 1, hd(8'h09, 8'h11, 16'h0008));
        put_r(1, 1, 1, 32'hDEAD_BEEF);
        o_ready = 1'b1;
        #1;
        check("R10 passthrough data", o_data, hd(8'h09, 8'h11, 16'h0008));
        check("R10 valid", o_valid, 1'b1);
        check("R10 mirror held", r_ready, 1'b0);
        o_ready = 1'b0;
        #1;
        check("R10 ready follows", m_ready, 1'b0);
        o_ready = 1'b1;
        step(); step();
        check("R10 no error", err_flag, 1'b0);
        check("R10 wait kept", wait_cycles, 16'd3);
        idle_in();
        cfg_master = 1'b1;
        step();
    endtask

    task automatic t_stall();
        o_ready = 1'b0;
        put_m(1, 1, 1, hd(8'h05, 8'h11, 16'h0009));
        put_r(1, 1, 1, hd(8'h05, 8'h22, 16'h0009));
        for (int i = 0; i < 3; i++) begin
            #1;
            check("R2 stalled m_ready", m_ready, 1'b0);
            check("R2 stalled r_ready", r_ready, 1'b0);
            step();
        end
        o_ready = 1'b1;
        step();
        idle_in();
        check("R9 stall not waiting", wait_cycles, 16'd0);
        check("R2 no error", err_flag, 1'b0);
    endtask

    initial begin
        idle_in();
        repeat (3) step();
        rst_n = 1'b1;
        step();
        t_reset();
        t_match();
        t_bad_src();
        t_dst_diff();
        t_body_diff();
        t_tail_diff();
        t_wait();
        t_slave();
        t_stall();
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule